// File: doc/BRIEF.md
# DTMF Transceiver Host Register Controller

This block is the register file that a host processor sees in a DTMF transceiver. The host reaches it over a 4-bit data bus. That bus uses an active-low chip select, a read/write line, one register-select line and a strobe that need not run between transfers. The bus is split into an input half, an output half and an output-enable. A pad ring merges them into one bidirectional bus. Through this bus the host writes the code of the tone pair to send, reads the last decoded code, programs two control registers that share one address, and polls a status register whose event flags clear once they have been read.

The receiver and the transmitter sit outside this block. The receiver hands in each newly decoded code with a one-cycle `rx_valid` pulse. There is no back-pressure: every pulse is accepted, and a new code overwrites an older unread one. The receiver also supplies a level that reports the tone-absent steering state. The transmitter reports the end of each burst-and-pause with a `tx_ready` pulse. The block returns the transmit code together with a one-cycle load pulse, and it returns the decoded control fields as plain level outputs. From the status flags it drives an active-low interrupt request.

Top module: `hostreg_ctrl`

## Requirements
- R1: A transfer is decoded from {rsel, rw}. 00 writes the transmit code, 01 reads the receive code, 10 writes the control address, and 11 reads the status register.
- R2: A transmit write updates `tx_code` with the bus nibble and raises `tx_load` for exactly one clock.
- R3: Control register A holds bit0 tone enable, bit1 call-progress mode (1 = call progress), bit2 interrupt enable and bit3 B-select. A control write with bit3 = 1 sends only the next control write to register B. Register B holds bit0 burst disable (0 = burst on), bit1 test, bit2 single tone and bit3 column select. The control write after a register-B write goes to register A again.
- R4: After reset both control registers are 0, which selects DTMF mode with burst on. Status bits 0 to 2 are 0, `irq_n` is 1 and `data_oe` is 0.
- R5: An `rx_valid` pulse stores `rx_code` as the receive code and sets the receive-full flag. A receive read returns the stored code.
- R6: The status nibble reads as bit0 interrupt flag, bit1 transmit-empty, bit2 receive-full and bit3 tone-absent. A status read returns the flag values from before the read. Bits 0 to 2 clear only when the read completes. A set event in the same cycle wins over the clear.
- R7: A `tx_ready` pulse sets transmit-empty only while burst is on. Transmit-empty is held clear while burst is off.
- R8: The interrupt flag is set whenever receive-full or transmit-empty is set.
- R9: `irq_n` is low exactly when the interrupt flag is 1, interrupt enable is 1 and DTMF mode is selected.
- R10: `data_oe` is 1 only while `cs_n` is 0, `rw` is 1 and `strobe` is 1.
- R11: Transfers act on the falling strobe edge after synchronization to `clk`. A strobe with `cs_n` high changes no register.
- R12: Status bit3 follows the `tone_absent` input, registered once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | 1 = read, 0 = write |
| rsel | input | 1 | Register select |
| strobe | input | 1 | Asynchronous transfer strobe |
| data_in | input | 4 | Bus write data |
| data_out | output | 4 | Bus read data |
| data_oe | output | 1 | Bus output enable |
| rx_valid | input | 1 | New decoded code pulse |
| rx_code | input | 4 | Decoded code |
| tone_absent | input | 1 | Tone-absent steering level |
| tx_ready | input | 1 | Burst-and-pause finished pulse |
| tx_code | output | 4 | Code to transmit |
| tx_load | output | 1 | One-cycle transmit code strobe |
| tone_en | output | 1 | Control A bit0 |
| cp_mode | output | 1 | Control A bit1 |
| irq_en | output | 1 | Control A bit2 |
| burst_off | output | 1 | Control B bit0 |
| test_mode | output | 1 | Control B bit1 |
| single_tone | output | 1 | Control B bit2 |
| column_sel | output | 1 | Control B bit3 |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
A bus write takes effect on the third rising clock edge after `strobe` falls: two synchronizer stages, then the register. The bench therefore holds `cs_n` low and waits four clocks before it checks anything that write could change. Read data and `data_oe` follow the registers and the bus lines with no clock, so the bench samples them after `strobe` has been high for three clocks and before it lowers the strobe. The `rx_valid` and `tx_ready` pulses show up in the flags and in `irq_n` one clock after the pulse, and the bench waits two clocks before it compares them with its own model.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;
  localparam int NIB = 4;

  typedef enum logic [1:0] {
    OP_TX_WR  = 2'b00,
    OP_RX_RD  = 2'b01,
    OP_CTL_WR = 2'b10,
    OP_ST_RD  = 2'b11
  } bus_op_e;

  typedef struct packed {
    logic b_sel;
    logic irq_en;
    logic cp_mode;
    logic tone_en;
  } ctl_a_t;

  typedef struct packed {
    logic column;
    logic single;
    logic test;
    logic burst_off;
  } ctl_b_t;

  typedef struct packed {
    logic tone_absent;
    logic rx_full;
    logic tx_empty;
    logic irq_flag;
  } stat_t;
endpackage

// File: rtl/hostreg_bus_sync.sv
module hostreg_bus_sync
  import hostreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    strobe,
  input  logic    cs_n,
  input  logic    rw,
  input  logic    rsel,
  output logic    xfer,
  output bus_op_e op
);
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[LAST-1:0], strobe};
  end

  assign xfer = sh[LAST] & ~sh[LAST-1] & ~cs_n;
  assign op   = bus_op_e'({rsel, rw});

  AST_XFER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !xfer); // R11
endmodule

// File: rtl/hostreg_ctrl_regs.sv
module hostreg_ctrl_regs
  import hostreg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [NIB-1:0] din,
  output ctl_a_t         cra,
  output ctl_b_t         crb
);
  logic sel_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cra   <= '0;
      crb   <= '0;
      sel_b <= 1'b0;
    end else if (wr) begin
      if (sel_b) begin
        crb   <= ctl_b_t'(din);
        sel_b <= 1'b0;
      end else begin
        cra   <= ctl_a_t'(din);
        sel_b <= din[NIB-1];
      end
    end
  end

  AST_B_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel_b) |=> !sel_b); // R3
  AST_B_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !sel_b) |=> $stable(crb)); // R3
endmodule

// File: rtl/hostreg_status.sv
module hostreg_status
  import hostreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rx_set,
  input  logic  tx_set,
  input  logic  burst_en,
  input  logic  rd_clr,
  input  logic  tone_absent,
  input  logic  ie,
  input  logic  cp,
  output stat_t stat,
  output logic  irq_n
);
  logic tx_take;

  assign tx_take = tx_set & burst_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
    end else begin
      stat.tone_absent <= tone_absent;
      stat.rx_full     <= rx_set | (stat.rx_full & ~rd_clr);
      stat.tx_empty    <= burst_en & (tx_set | (stat.tx_empty & ~rd_clr));
      stat.irq_flag    <= rx_set | tx_take | (stat.irq_flag & ~rd_clr);
    end
  end

  assign irq_n = ~(stat.irq_flag & ie & ~cp);

  AST_RXF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_set |=> stat.rx_full); // R5
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !rx_set) |=> !stat.rx_full); // R6
  AST_TXE_BURST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_en |=> !stat.tx_empty); // R7
  AST_FLAG_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat.rx_full || stat.tx_empty) |-> stat.irq_flag); // R8
endmodule

// File: rtl/hostreg_ctrl.sv
module hostreg_ctrl
  import hostreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           rw,
  input  logic           rsel,
  input  logic           strobe,
  input  logic [NIB-1:0] data_in,
  output logic [NIB-1:0] data_out,
  output logic           data_oe,
  input  logic           rx_valid,
  input  logic [NIB-1:0] rx_code,
  input  logic           tone_absent,
  input  logic           tx_ready,
  output logic [NIB-1:0] tx_code,
  output logic           tx_load,
  output logic           tone_en,
  output logic           cp_mode,
  output logic           irq_en,
  output logic           burst_off,
  output logic           test_mode,
  output logic           single_tone,
  output logic           column_sel,
  output logic           irq_n
);
  logic           xfer;
  bus_op_e        op;
  ctl_a_t         cra;
  ctl_b_t         crb;
  stat_t          stat;
  logic [NIB-1:0] rx_q;

  hostreg_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cs_n(cs_n),
    .rw(rw), .rsel(rsel), .xfer(xfer), .op(op)
  );

  hostreg_ctrl_regs u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(xfer && op == OP_CTL_WR),
    .din(data_in), .cra(cra), .crb(crb)
  );

  hostreg_status u_stat (
    .clk(clk), .rst_n(rst_n), .rx_set(rx_valid), .tx_set(tx_ready),
    .burst_en(~crb.burst_off), .rd_clr(xfer && op == OP_ST_RD),
    .tone_absent(tone_absent), .ie(cra.irq_en), .cp(cra.cp_mode),
    .stat(stat), .irq_n(irq_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q    <= '0;
      tx_code <= '0;
      tx_load <= 1'b0;
    end else begin
      if (rx_valid) rx_q <= rx_code;
      tx_load <= xfer && op == OP_TX_WR;
      if (xfer && op == OP_TX_WR) tx_code <= data_in;
    end
  end

  assign data_oe  = ~cs_n & rw & strobe;
  assign data_out = rsel ? NIB'(stat) : rx_q;

  assign tone_en     = cra.tone_en;
  assign cp_mode     = cra.cp_mode;
  assign irq_en      = cra.irq_en;
  assign burst_off   = crb.burst_off;
  assign test_mode   = crb.test;
  assign single_tone = crb.single;
  assign column_sel  = crb.column;

  AST_TXLOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_load); // R2
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |=> $stable(tx_code)); // R11
endmodule

// File: tb/tb_hostreg_ctrl.sv
`timescale 1ns/1ps
module tb_hostreg_ctrl;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, rw = 0, rsel = 0, strobe = 0;
  logic [3:0] data_in = 0, data_out, rx_code = 0, tx_code;
  logic data_oe, rx_valid = 0, tone_absent = 0, tx_ready = 0, tx_load;
  logic tone_en, cp_mode, irq_en, burst_off, test_mode, single_tone, column_sel, irq_n;

  int total = 0, fails = 0, loads = 0, exp_loads = 0;
  logic [3:0] m_cra = 0, m_crb = 0, m_rx = 0, m_tx = 0;
  logic m_selb = 0, m_rxf = 0, m_txe = 0, m_irqf = 0;

  always #2 clk = ~clk;

  hostreg_ctrl dut (.*);

  always @(negedge clk) if (rst_n && tx_load) loads++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_stat();
    return {tone_absent, m_rxf, m_txe, m_irqf};
  endfunction

  function automatic logic exp_irq_n();
    return !(m_irqf && m_cra[2] && !m_cra[1]);
  endfunction

  task automatic bus(input logic sel, input logic r, input logic cs,
                     input logic [3:0] d, output logic [3:0] q, output logic oe);
    @(negedge clk);
    cs_n = cs; rsel = sel; rw = r; data_in = d; strobe = 1;
    repeat (3) @(negedge clk);
    q = data_out; oe = data_oe;
    strobe = 0;
    repeat (4) @(negedge clk);
    cs_n = 1; rw = 0;
  endtask

  task automatic check_outs(string tag);
    chk({"R3 ctlA ", tag}, {irq_en, cp_mode, tone_en}, m_cra[2:0]);
    chk({"R3 ctlB ", tag}, {column_sel, single_tone, test_mode, burst_off}, m_crb);
    chk({"R9 irq_n ", tag}, irq_n, exp_irq_n());
    chk({"R2 tx_code ", tag}, tx_code, m_tx);
  endtask

  task automatic ctl_wr(input logic [3:0] d);
    logic [3:0] q; logic oe;
    bus(1, 0, 0, d, q, oe);
    if (m_selb) begin m_crb = d; m_selb = 0; end
    else begin m_cra = d; m_selb = d[3]; end
    if (m_crb[0]) m_txe = 0;
  endtask

  task automatic st_rd(string tag);
    logic [3:0] q; logic oe;
    bus(1, 1, 0, 0, q, oe);
    chk({"R6 status ", tag}, q, exp_stat());
    chk({"R10 oe on read ", tag}, oe, 1);
    m_rxf = 0; m_txe = 0; m_irqf = 0;
  endtask

  task automatic rx_ev(input logic [3:0] c);
    @(negedge clk); rx_valid = 1; rx_code = c;
    @(negedge clk); rx_valid = 0;
    @(negedge clk);
    m_rx = c; m_rxf = 1; m_irqf = 1;
  endtask

  task automatic tx_ev();
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
    @(negedge clk);
    if (!m_crb[0]) begin m_txe = 1; m_irqf = 1; end
  endtask

  initial begin
    #(4 * 200000);
    fails++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [3:0] q; logic oe;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_outs("reset R4");
    chk("R4 oe idle", data_oe, 0);
    st_rd("reset R4");

    // R3: shared address, one-shot B select
    ctl_wr(4'b1000); ctl_wr(4'b0101); ctl_wr(4'b0010);
    check_outs("R3 seq");
    // R7: burst off blocks transmit-empty
    tx_ev(); st_rd("R7 burst off");
    ctl_wr(4'b1100); ctl_wr(4'b0000);
    tx_ev(); check_outs("R9 irq on");
    chk("R9 irq low", irq_n, 0);
    st_rd("R8 txe+irq");
    // R6: pre-clear value seen, then clear
    rx_ev(4'hB); st_rd("R6 first"); st_rd("R6 second");
    // R5: receive read
    bus(0, 1, 0, 0, q, oe); chk("R5 rx code", q, 4'hB);
    // R11: deselected strobe does nothing
    bus(0, 0, 1, 4'h7, q, oe); check_outs("R11 deselected");
    chk("R10 oe deselected", oe, 0);

    for (int i = 0; i < 400; i++) begin
      int k;
      logic [3:0] d;
      k = $urandom_range(0, 7);
      d = 4'($urandom);
      tone_absent = $urandom_range(0, 1) == 1;
      repeat (2) @(negedge clk);
      case (k)
        0: begin bus(0, 0, 0, d, q, oe); m_tx = d; exp_loads++; end
        1: begin bus(0, 1, 0, 0, q, oe); chk("R5 rx read", q, m_rx); end
        2, 3: ctl_wr(d);
        4: st_rd("R12 rand");
        5: rx_ev(d);
        6: tx_ev();
        default: begin
          bus(d[0], d[1], 1, d, q, oe);
          chk("R11 deselect oe", oe, 0);
        end
      endcase
      check_outs("R1 rand");
    end
    repeat (3) @(negedge clk);
    chk("R2 load pulses", loads, exp_loads);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule